// File: doc/BRIEF.md
# Paged Bus-to-Local Address Map

This block turns 22-bit addresses from an external bus master into 24-bit local memory addresses. Bus space is cut into 512-byte pages. Each page has its own map entry, which holds a valid flag and a 15-bit local page frame. A lookup on a page whose entry is valid reports a hit and returns the frame joined to the untouched 9-bit page offset. A lookup on a page whose entry is not valid reports a miss, so the surrounding logic gives that bus cycle no response at all.

The host reaches the entries as 32-bit longword registers in a fixed physical window that starts at 0x20088000, with one entry every four bytes. The full map has 8192 entries (`IDX_W` = 13). The default build uses 1024 entries (`IDX_W` = 10) to keep elaboration small. In a reduced build, bus pages and host offsets that fall past the last entry are treated as unmapped. The lookup result and the host read data each appear one clock after the request.

Top module: `busmap_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. The host read data and lookup outputs are zero while idle.
- R2: A lookup on a valid page raises `xl_hit` exactly one clock after `xl_req`, with `xl_laddr` = {frame[14:0], xl_addr[8:0]}.
- R3: A lookup on a page whose valid bit is clear gives `xl_hit` = 0 and `xl_laddr` = 0.
- R4: Entry layout: bit 31 is the valid flag and bits 14:0 are the frame. Bits 30:15 are discarded on write and always read back as zero.
- R5: An entry sits at host address 0x20088000 + 4*index, with index taken from hst_addr[14:2] and hst_addr[1:0] ignored. An access outside the window writes nothing, and a read there returns zero.
- R6: A write changes an entry only when `hst_be` = 4'b1111. Any partial byte-enable write leaves the entry unchanged.
- R7: The entry index for a lookup is xl_addr[21:9]. A bus page or host offset at or beyond 2^IDX_W entries always misses and writes nothing.
- R8: Host read data appears one clock after a decoded read (`hst_sel`=1, `hst_wr`=0) and is zero in every other cycle.
- R9: A lookup or read in the same cycle as a write to the same entry sees the old contents. From the next cycle on it sees the new contents.
- R10: Writing an entry with bit 31 clear unmaps that page, and the frame is still kept for read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 32 | Host physical byte address |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one clock after the read |
| xl_req | input | 1 | Lookup request |
| xl_addr | input | 22 | Bus address to translate |
| xl_hit | output | 1 | Lookup hit, one clock after the request |
| xl_laddr | output | 24 | Local address, zero on a miss |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:
- **Same-cycle write and lookup.** A design that forwards the new value would hit one cycle early.
- **Partial byte-enable write.** A design that honours it would corrupt a live entry.
- **Garbage in bits 30:15.** A design that keeps those bits would leak them on read-back.
- **Access just outside the window or past the last entry.** A design with a loose address compare would alias onto a real entry, which shows up as a wrong hit or stray read data.
- **Clearing a valid bit and probing page 0 and the last page.** These catch stale mappings and index slicing off by one.

// File: rtl/busmap_pkg.sv
`timescale 1ns/1ps
package busmap_pkg;
  localparam int BUS_AW     = 22;
  localparam int LCL_AW     = 24;
  localparam int PG_OFS_W   = 9;
  localparam int FRAME_W    = LCL_AW - PG_OFS_W;
  localparam int MAX_IDX_W  = BUS_AW - PG_OFS_W;
  localparam int HOST_AW    = 32;
  localparam int WIN_LSB    = MAX_IDX_W + 2;
  localparam logic [HOST_AW-WIN_LSB-1:0] WIN_TAG = 17'h04011;
  localparam int VALID_BIT  = 31;
endpackage

// File: rtl/busmap_hostdec.sv
`timescale 1ns/1ps
module busmap_hostdec
  import busmap_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic               hst_sel,
  input  logic               hst_wr,
  input  logic [31:0]        hst_addr,
  input  logic [3:0]         hst_be,
  input  logic [31:0]        hst_wdata,
  output logic               wr_en,
  output logic               rd_en,
  output logic [IDX_W-1:0]   idx,
  output logic               wr_valid,
  output logic [FRAME_W-1:0] wr_frame
);
  logic [MAX_IDX_W-1:0] win_ofs;
  logic                 in_win;
  logic                 unused_bits;

  assign win_ofs = hst_addr[WIN_LSB-1:2];
  assign unused_bits = ^{hst_addr[1:0], hst_wdata[30:FRAME_W]};

  always_comb begin
    in_win   = (hst_addr[HOST_AW-1:WIN_LSB] == WIN_TAG) &&
               ((win_ofs >> IDX_W) == '0);
    idx      = win_ofs[IDX_W-1:0];
    wr_en    = hst_sel && hst_wr && in_win && (hst_be == 4'b1111);
    rd_en    = hst_sel && !hst_wr && in_win;
    wr_valid = hst_wdata[VALID_BIT];
    wr_frame = hst_wdata[FRAME_W-1:0];
  end
endmodule

// File: rtl/busmap_table.sv
`timescale 1ns/1ps
module busmap_table
  import busmap_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int RD_PORTS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              wr_valid,
  input  logic [FRAME_W-1:0]                wr_frame,
  input  logic [RD_PORTS-1:0]               rd_en,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx,
  output logic [RD_PORTS-1:0]               rd_valid,
  output logic [RD_PORTS-1:0][FRAME_W-1:0]  rd_frame
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [FRAME_W-1:0] frame_mem [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] vld_d;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) frame_mem[wr_idx] <= wr_frame;
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_valid[g] <= 1'b0;
      else if (rd_en[g]) rd_valid[g] <= vld_q[rd_idx[g]];
    end
    always_ff @(posedge clk) begin
      if (rd_en[g]) rd_frame[g] <= frame_mem[rd_idx[g]];
    end
  end
endmodule

// File: rtl/busmap_resp.sv
`timescale 1ns/1ps
module busmap_resp
  import busmap_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xl_go,
  input  logic [PG_OFS_W-1:0]       xl_ofs,
  input  logic                      hrd_go,
  input  logic [1:0]                tbl_valid,
  input  logic [1:0][FRAME_W-1:0]   tbl_frame,
  output logic                      xl_hit,
  output logic [LCL_AW-1:0]         xl_laddr,
  output logic [31:0]               hst_rdata
);
  logic                xl_pend_q, xl_pend_d;
  logic                hrd_pend_q, hrd_pend_d;
  logic [PG_OFS_W-1:0] ofs_q;

  always_comb begin
    xl_pend_d  = xl_go;
    hrd_pend_d = hrd_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_pend_q  <= 1'b0;
      hrd_pend_q <= 1'b0;
    end else begin
      xl_pend_q  <= xl_pend_d;
      hrd_pend_q <= hrd_pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (xl_go) ofs_q <= xl_ofs;
  end

  always_comb begin
    xl_hit    = xl_pend_q && tbl_valid[0];
    xl_laddr  = xl_hit ? {tbl_frame[0], ofs_q} : '0;
    hst_rdata = hrd_pend_q ? {tbl_valid[1], {(31-FRAME_W){1'b0}}, tbl_frame[1]} : '0;
  end
endmodule

// File: rtl/busmap_xlate.sv
`timescale 1ns/1ps
module busmap_xlate
  import busmap_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_sel,
  input  logic        hst_wr,
  input  logic [31:0] hst_addr,
  input  logic [3:0]  hst_be,
  input  logic [31:0] hst_wdata,
  output logic [31:0] hst_rdata,
  input  logic        xl_req,
  input  logic [21:0] xl_addr,
  output logic        xl_hit,
  output logic [23:0] xl_laddr
);
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic                     wr_en, hrd_en, wr_valid;
  logic [IDX_W-1:0]         host_idx;
  logic [FRAME_W-1:0]       wr_frame;
  logic [MAX_IDX_W-1:0]     bus_pg;
  logic                     xl_go;
  logic [1:0]               rd_en;
  logic [1:0][IDX_W-1:0]    rd_idx;
  logic [1:0]               rd_valid;
  logic [1:0][FRAME_W-1:0]  rd_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    bus_pg    = xl_addr[BUS_AW-1:PG_OFS_W];
    xl_go     = xl_req && ((bus_pg >> IDX_W) == '0);
    rd_en     = {hrd_en, xl_go};
    rd_idx[0] = bus_pg[IDX_W-1:0];
    rd_idx[1] = host_idx;
  end

  busmap_hostdec #(.IDX_W(IDX_W)) u_dec (
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_be(hst_be),
    .hst_wdata(hst_wdata), .wr_en(wr_en), .rd_en(hrd_en), .idx(host_idx),
    .wr_valid(wr_valid), .wr_frame(wr_frame)
  );

  busmap_table #(.IDX_W(IDX_W), .RD_PORTS(2)) u_tbl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(host_idx),
    .wr_valid(wr_valid), .wr_frame(wr_frame), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_frame(rd_frame)
  );

  busmap_resp u_resp (
    .clk(clk), .rst_n(rst_int_n), .xl_go(xl_go), .xl_ofs(xl_addr[PG_OFS_W-1:0]),
    .hrd_go(hrd_en), .tbl_valid(rd_valid), .tbl_frame(rd_frame),
    .xl_hit(xl_hit), .xl_laddr(xl_laddr), .hst_rdata(hst_rdata)
  );
endmodule

// File: rtl/busmap_chk.sv
`timescale 1ns/1ps
module busmap_chk #(
  parameter int IDX_W = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_sel,
  input logic        hst_wr,
  input logic [31:0] hst_rdata,
  input logic        xl_req,
  input logic [21:0] xl_addr,
  input logic        xl_hit,
  input logic [23:0] xl_laddr
);
  logic [12:0] chk_pg;
  assign chk_pg = xl_addr[21:9];

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_hit |-> (xl_laddr == 24'h0));

  assert_hit_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> $past(xl_req));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> (xl_laddr[8:0] == $past(xl_addr[8:0])));

  assert_beyond_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && ((chk_pg >> IDX_W) != 13'h0)) |=> !xl_hit);

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rdata[30:15] == 16'h0);

  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_sel && !hst_wr) |=> (hst_rdata == 32'h0));
endmodule

bind busmap_xlate busmap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
  .hst_rdata(hst_rdata), .xl_req(xl_req), .xl_addr(xl_addr),
  .xl_hit(xl_hit), .xl_laddr(xl_laddr)
);

// File: tb/tb_busmap_xlate.sv
`timescale 1ns/1ps
module tb_busmap_xlate;
  localparam int IDX_W = 10;
  localparam int ENT   = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_sel, hst_wr, xl_req;
  logic [31:0] hst_addr, hst_wdata, hst_rdata;
  logic [3:0]  hst_be;
  logic [21:0] xl_addr;
  logic        xl_hit;
  logic [23:0] xl_laddr;

  always #5 clk = ~clk;

  busmap_xlate #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_be(hst_be), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_hit(xl_hit), .xl_laddr(xl_laddr)
  );

  typedef struct {
    logic        hit;
    logic [23:0] la;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  logic        m_vld [ENT];
  logic [14:0] m_frm [ENT];

  function automatic logic [31:0] ra(input int idx);
    return 32'h2008_8000 + 32'(idx) * 4;
  endfunction

  task automatic cyc(input logic sel, input logic wr, input logic [31:0] ha,
                     input logic [3:0] be, input logic [31:0] wd,
                     input logic xr, input logic [21:0] xa, input string tag);
    exp_t e;
    logic in_win;
    int   hi, pi;
    @(posedge clk); #1;
    hst_sel = sel; hst_wr = wr; hst_addr = ha; hst_be = be; hst_wdata = wd;
    xl_req = xr; xl_addr = xa;
    in_win = (ha[31:15] == 17'h04011) && (ha[14:12] == 3'b000);
    hi = int'(ha[11:2]);
    pi = int'(xa[18:9]);
    e.tag = tag;
    e.rd  = (sel && !wr && in_win) ? {m_vld[hi], 16'h0, m_frm[hi]} : 32'h0;
    e.hit = xr && (xa[21:19] == 3'b000) && m_vld[pi];
    e.la  = e.hit ? {m_frm[pi], xa[8:0]} : 24'h0;
    sb.push_back(e);
    if (sel && wr && in_win && be == 4'hF) begin
      m_vld[hi] = wd[31];
      m_frm[hi] = wd[14:0];
    end
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0, 22'h0, tag);
  endtask

  always @(negedge clk) begin
    if (sb.size() >= 2) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (xl_hit !== e.hit || xl_laddr !== e.la || hst_rdata !== e.rd) begin
        n_fail++;
        $display("FAIL %s: act hit=%0b la=%06h rd=%08h exp hit=%0b la=%06h rd=%08h",
                 e.tag, xl_hit, xl_laddr, hst_rdata, e.hit, e.la, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 1'b0; m_frm[i] = 15'h0; end
    rst_n = 1'b0; hst_sel = 0; hst_wr = 0; hst_addr = 0; hst_be = 0;
    hst_wdata = 0; xl_req = 0; xl_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (xl_hit !== 1'b0 || xl_laddr !== 24'h0 || hst_rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: act %0b %06h %08h exp 0 0 0", xl_hit, xl_laddr, hst_rdata);
    end
    // R1: unprogrammed pages miss
    cyc(0, 0, 0, 0, 0, 1, {13'd5, 9'h1AB}, "R1 lookup after reset");
    cyc(0, 0, 0, 0, 0, 1, {13'd0, 9'h000}, "R1 page 0 after reset");
    // R9: write and lookup same page in same cycle sees old
    cyc(1, 1, ra(5), 4'hF, 32'h8000_1234, 1, {13'd5, 9'h1AB}, "R9 same cycle old");
    cyc(0, 0, 0, 0, 0, 1, {13'd5, 9'h1AB}, "R2 R9 hit next cycle");
    cyc(0, 0, 0, 0, 0, 1, {13'd5, 9'h000}, "R2 offset zero");
    // R4: junk in 30:15 dropped
    cyc(1, 1, ra(7), 4'hF, 32'hFFFF_7FFF, 0, 0, "R4 write junk");
    cyc(1, 0, ra(7), 4'hF, 0, 1, {13'd7, 9'h1FF}, "R4 readback R2 max frame");
    // R6: partial writes ignored
    cyc(1, 1, ra(5), 4'b0111, 32'h0, 0, 0, "R6 partial write");
    cyc(1, 1, ra(5), 4'b1000, 32'h0, 0, 0, "R6 partial write top");
    cyc(1, 0, ra(5), 4'hF, 0, 1, {13'd5, 9'h0F0}, "R6 entry unchanged");
    // R5: window decode
    cyc(1, 1, 32'h2009_0014, 4'hF, 32'h0, 0, 0, "R5 write above window");
    cyc(1, 1, 32'h2008_0014, 4'hF, 32'h0, 0, 0, "R5 write below window");
    cyc(1, 0, 32'h2009_0014, 4'hF, 0, 1, {13'd5, 9'h011}, "R5 read outside zero");
    cyc(1, 0, ra(5) + 32'd2, 4'hF, 0, 0, 0, "R5 low addr bits ignored");
    // R7: beyond table
    cyc(1, 1, 32'h2008_9018, 4'hF, 32'h0, 0, 0, "R7 host offset past table");
    cyc(1, 0, 32'h2008_9018, 4'hF, 0, 0, 0, "R7 read past table zero");
    cyc(1, 1, ra(6), 4'hF, 32'h8000_4321, 0, 0, "R7 program page 6");
    cyc(0, 0, 0, 0, 0, 1, {13'd1030, 9'h055}, "R7 aliased page misses");
    cyc(0, 0, 0, 0, 0, 1, {13'd6, 9'h055}, "R7 page 6 hits");
    // edges of table
    cyc(1, 1, ra(0), 4'hF, 32'h8000_0001, 0, 0, "R2 program page 0");
    cyc(1, 1, ra(ENT-1), 4'hF, 32'h8000_2AAA, 1, {13'd0, 9'h100}, "R2 page 0 hit");
    cyc(0, 0, 0, 0, 0, 1, {13'(ENT-1), 9'h1FE}, "R2 last page hit");
    // R10: clear valid
    cyc(1, 1, ra(5), 4'hF, 32'h0000_1234, 1, {13'd5, 9'h003}, "R10 R9 clear same cycle");
    cyc(1, 0, ra(5), 4'hF, 0, 1, {13'd5, 9'h003}, "R10 R3 unmapped miss");
    cyc(1, 0, ra(6), 4'hF, 0, 1, {13'd6, 9'h1C0}, "R10 neighbour intact");
    // R8: idle read data
    cyc(1, 1, ra(6), 4'hF, 32'h8000_0777, 0, 0, "R8 write gives no read data");
    idle("R8 idle");
    cyc(1, 0, ra(6), 4'hF, 0, 1, {13'd6, 9'h002}, "R8 R2 read new frame");
    idle("R8 idle after read");
    idle("flush");
    idle("flush");
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule